// File: doc/BRIEF.md
# Audio DMA bridge channel controller

This block moves audio words between memory and the audio side of one audio unit, in both directions. The playback lane fetches 32-bit words from a ring buffer in memory and hands them to a transmit stream. The record lane takes words from a receive stream and stores them into a second ring buffer. Software programs a word-aligned base address and a byte length for each lane, and then sets that lane's enable bit in the shared control word.

Each lane tracks its current address and the bytes still to move, and counts down by four on every word the memory port grants. The lane raises a half event when the remaining count first drops to half the programmed length or below. It raises a full event when the count reaches zero. With loop mode set, the lane then goes back to its base address and full length on its own, so the buffer runs as an endless ring with two interrupts per pass. Without loop mode, the lane goes idle. A stop bit for each lane ends that lane's transfer at once.

The four events are sticky bits that software clears by writing 1 to them. They also drive four interrupt lines: playback half, playback full, record half, record full.

Top module: `audio_dma_bridge`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and no memory request, transmit valid or receive ready is asserted.
- R2: Byte offsets 0x00 and 0x04 hold the playback and record base addresses, and bits 1:0 always read 0. Offsets 0x08 and 0x0C hold the playback and record lengths, and only bits 25:2 are kept, so the largest length is 0x03FFFFFC.
- R3: The control word is at offset 0x10. The playback lane uses bit 0 (enable), bit 1 (stop), bit 2 (loop) and bits 9:8 (alignment mode, 0 none, 1 four-byte, 2 two-word). The record lane uses bits 16, 17, 18 and 25:24 for the same functions. Loop and alignment read back as written, stop reads 0, and enable reads 1 only while the lane runs.
- R4: Writing enable=1 to an idle lane whose length is at least 8 starts it at its base address. Each granted memory word advances the address by 4 and lowers the remaining count by 4. The remaining counts read back at 0x14 (playback) and 0x18 (record).
- R5: Enable on a lane whose length is below 8 bytes is ignored: the lane stays idle and makes no memory request.
- R6: A lane sets its half event (`irq[0]` playback, `irq[2]` record) when the remaining count first becomes no more than half the length. It sets its full event (`irq[1]`, `irq[3]`) when the count reaches 0. For any length of 8 or more, the half event comes in an earlier cycle than the full event.
- R7: The events are sticky bits at offset 0x1C, with bit k driving `irq[k]`. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: With loop set, reaching count 0 reloads the base address and the full length, and the lane keeps transferring.
- R9: With loop clear, reaching count 0 clears the lane's enable, and no further memory request is made.
- R10: Writing 1 to a lane's stop bit halts that lane from the next cycle. Enable reads 0, a word held in the lane is dropped, and no memory request, transmit valid or receive ready follows.
- R11: Writing enable=1 to a running lane does not restart it. Writing enable=0 without stop does not halt it.
- R12: Playback words appear on `txs_data` in address order and stay stable until `txs_ready`. Record words are written to consecutive addresses in arrival order, and the address and data stay stable until `rxm_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| txm_req | output | 1 | Playback memory read request |
| txm_addr | output | 32 | Playback read address |
| txm_gnt | input | 1 | Playback read grant, data valid this cycle |
| txm_rdata | input | 32 | Playback read data |
| txs_valid | output | 1 | Transmit stream word valid |
| txs_data | output | 32 | Transmit stream word |
| txs_ready | input | 1 | Transmit stream accepts word |
| rxs_valid | input | 1 | Receive stream word valid |
| rxs_data | input | 32 | Receive stream word |
| rxs_ready | output | 1 | Block accepts receive word |
| rxm_req | output | 1 | Record memory write request |
| rxm_addr | output | 32 | Record write address |
| rxm_wdata | output | 32 | Record write data |
| rxm_gnt | input | 1 | Record write grant |
| irq | output | 4 | Sticky events: playback half, playback full, record half, record full |

## Verification
The bench builds the block with its default parameters, a 26-bit count field and 32-bit addresses. Full-width writes then show the count masking at the 0x03FFFFFC limit. Because the lengths it programs are only 8 to 64 bytes, the half and full boundaries, a reload back to base and the sub-minimum length are all reached within a few dozen cycles. The memory and stream models can stall on request, so stops land while a word is held in a lane.

// File: rtl/adb_pkg.sv
package adb_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 5;
  localparam int NLANE = 2;
  localparam int LANE_STRIDE = 16;   // control-word bit distance between lanes
  localparam int BYTES_PER_WORD = 4;

  localparam logic [REG_AW-1:0] OFS_BASE   = 5'h00;  // +4 per lane
  localparam logic [REG_AW-1:0] OFS_LEN    = 5'h08;  // +4 per lane
  localparam logic [REG_AW-1:0] OFS_CTRL   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_LEFT   = 5'h14;  // +4 per lane
  localparam logic [REG_AW-1:0] OFS_EVENTS = 5'h1C;

  localparam int BIT_GO    = 0;
  localparam int BIT_HALT  = 1;
  localparam int BIT_LOOP  = 2;
  localparam int BIT_ALIGN = 8;

  localparam int MIN_LEN = 8;

  typedef enum logic [1:0] {
    ALIGN_NONE  = 2'd0,
    ALIGN_QUAD  = 2'd1,
    ALIGN_PAIR  = 2'd2,
    ALIGN_RSVD  = 2'd3
  } align_mode_e;
endpackage

// File: rtl/adb_regs.sv
module adb_regs
  import adb_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [REG_AW-1:0]             addr,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             rdata,
  input  logic [NLANE-1:0]              active_i,
  input  logic [NLANE-1:0][CNT_W-1:0]   left_i,
  input  logic [NLANE-1:0]              ev_half_i,
  input  logic [NLANE-1:0]              ev_full_i,
  output logic [NLANE-1:0][WORD_W-1:0]  base_o,
  output logic [NLANE-1:0][CNT_W-1:0]   len_o,
  output logic [NLANE-1:0]              loop_o,
  output logic [NLANE-1:0]              start_o,
  output logic [NLANE-1:0]              stop_o,
  output logic [2*NLANE-1:0]            irq_o
);
  localparam int EV_W = 2 * NLANE;

  logic [NLANE-1:0][WORD_W-1:0] base_q, base_d;
  logic [NLANE-1:0][CNT_W-1:0]  len_q, len_d;
  logic [NLANE-1:0]             loop_q, loop_d;
  align_mode_e [NLANE-1:0]      align_q, align_d;
  logic [EV_W-1:0]              ev_q, ev_d, ev_set, ev_clr;

  always_comb begin
    base_d  = base_q;
    len_d   = len_q;
    loop_d  = loop_q;
    align_d = align_q;
    for (int l = 0; l < NLANE; l++) begin
      ev_set[2*l]   = ev_half_i[l];
      ev_set[2*l+1] = ev_full_i[l];
      start_o[l] = we && (addr == OFS_CTRL) && wdata[LANE_STRIDE*l + BIT_GO];
      stop_o[l]  = we && (addr == OFS_CTRL) && wdata[LANE_STRIDE*l + BIT_HALT];
      if (addr == OFS_BASE + REG_AW'(4*l))
        base_d[l] = {wdata[WORD_W-1:2], 2'b00};
      if (addr == OFS_LEN + REG_AW'(4*l))
        len_d[l] = {wdata[CNT_W-1:2], 2'b00};
      if (addr == OFS_CTRL) begin
        loop_d[l]  = wdata[LANE_STRIDE*l + BIT_LOOP];
        align_d[l] = align_mode_e'(wdata[LANE_STRIDE*l + BIT_ALIGN +: 2]);
      end
    end
    ev_clr = (we && addr == OFS_EVENTS) ? wdata[EV_W-1:0] : '0;
    ev_d   = (ev_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      loop_q  <= '0;
      align_q <= {NLANE{ALIGN_NONE}};
      ev_q    <= '0;
    end else begin
      if (we) begin
        base_q  <= base_d;
        len_q   <= len_d;
        loop_q  <= loop_d;
        align_q <= align_d;
      end
      ev_q <= ev_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int l = 0; l < NLANE; l++) begin
      if (addr == OFS_BASE + REG_AW'(4*l)) rdata = base_q[l];
      if (addr == OFS_LEN + REG_AW'(4*l))  rdata = WORD_W'(len_q[l]);
      if (addr == OFS_LEFT + REG_AW'(4*l)) rdata = WORD_W'(left_i[l]);
    end
    if (addr == OFS_CTRL) begin
      for (int l = 0; l < NLANE; l++) begin
        rdata[LANE_STRIDE*l + BIT_GO]         = active_i[l];
        rdata[LANE_STRIDE*l + BIT_LOOP]       = loop_q[l];
        rdata[LANE_STRIDE*l + BIT_ALIGN +: 2] = align_q[l];
      end
    end
    if (addr == OFS_EVENTS) rdata[EV_W-1:0] = ev_q;
  end

  assign base_o = base_q;
  assign len_o  = len_q;
  assign loop_o = loop_q;
  assign irq_o  = ev_q;
endmodule

// File: rtl/adb_lane.sv
module adb_lane
  import adb_pkg::*;
#(
  parameter bit IS_RX = 1'b0,  // 1: the sink side is memory, 0: the source side is memory
  parameter int CNT_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              loop_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  left_o,
  output logic [WORD_W-1:0] addr_o,
  output logic              ev_half_o,
  output logic              ev_full_o,
  input  logic              src_valid_i,
  input  logic [WORD_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              snk_valid_o,
  output logic [WORD_W-1:0] snk_data_o,
  input  logic              snk_ready_i
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(BYTES_PER_WORD);
  localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_LEN);

  logic              act_q, act_d;
  logic              hold_q, hold_d;
  logic              hseen_q, hseen_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              take, give, beat;
  logic [CNT_W-1:0]  left_dec;

  assign src_ready_o = act_q && !hold_q;
  assign snk_valid_o = hold_q;
  assign snk_data_o  = dat_q;
  assign take = src_valid_i && src_ready_o;
  assign give = snk_valid_o && snk_ready_i;
  assign beat = IS_RX ? give : take;
  assign left_dec = left_q - STEP;

  always_comb begin
    act_d     = act_q;
    hold_d    = hold_q;
    hseen_d   = hseen_q;
    dat_d     = dat_q;
    addr_d    = addr_q;
    left_d    = left_q;
    ev_half_o = 1'b0;
    ev_full_o = 1'b0;
    if (stop_i) begin
      act_d   = 1'b0;
      hold_d  = 1'b0;
      hseen_d = 1'b0;
    end else begin
      if (take) begin
        hold_d = 1'b1;
        dat_d  = src_data_i;
      end
      if (give) hold_d = 1'b0;
      if (start_i && !act_q && (len_i >= LEN_MIN)) begin
        act_d   = 1'b1;
        addr_d  = base_i;
        left_d  = len_i;
        hseen_d = 1'b0;
      end else if (beat && act_q) begin
        addr_d = addr_q + WORD_W'(BYTES_PER_WORD);
        left_d = left_dec;
        if (!hseen_q && (left_dec <= (len_i >> 1))) begin
          ev_half_o = 1'b1;
          hseen_d   = 1'b1;
        end
        if (left_dec == '0) begin
          ev_full_o = 1'b1;
          if (loop_i) begin
            addr_d  = base_i;
            left_d  = len_i;
            hseen_d = 1'b0;
          end else begin
            act_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      hold_q  <= 1'b0;
      hseen_q <= 1'b0;
      dat_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
    end else begin
      act_q   <= act_d;
      hold_q  <= hold_d;
      hseen_q <= hseen_d;
      if (take) dat_q <= dat_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
    end
  end

  assign active_o = act_q;
  assign left_o   = left_q;
  assign addr_o   = addr_q;
endmodule

// File: rtl/audio_dma_bridge.sv
module audio_dma_bridge
  import adb_pkg::*;
#(
  parameter int CNT_W = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        txm_req,
  output logic [31:0] txm_addr,
  input  logic        txm_gnt,
  input  logic [31:0] txm_rdata,
  output logic        txs_valid,
  output logic [31:0] txs_data,
  input  logic        txs_ready,
  input  logic        rxs_valid,
  input  logic [31:0] rxs_data,
  output logic        rxs_ready,
  output logic        rxm_req,
  output logic [31:0] rxm_addr,
  output logic [31:0] rxm_wdata,
  input  logic        rxm_gnt,
  output logic [3:0]  irq
);
  localparam int TX = 0;
  localparam int RX = 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NLANE-1:0]             lane_active, lane_start, lane_stop, lane_loop;
  logic [NLANE-1:0]             lane_half, lane_full;
  logic [NLANE-1:0][CNT_W-1:0]  lane_left, lane_len;
  logic [NLANE-1:0][WORD_W-1:0] lane_base;

  adb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .active_i(lane_active), .left_i(lane_left),
    .ev_half_i(lane_half), .ev_full_i(lane_full),
    .base_o(lane_base), .len_o(lane_len), .loop_o(lane_loop),
    .start_o(lane_start), .stop_o(lane_stop), .irq_o(irq)
  );

  // playback: memory is the source, transmit stream is the sink
  adb_lane #(.IS_RX(1'b0), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(lane_start[TX]), .stop_i(lane_stop[TX]), .loop_i(lane_loop[TX]),
    .base_i(lane_base[TX]), .len_i(lane_len[TX]),
    .active_o(lane_active[TX]), .left_o(lane_left[TX]), .addr_o(txm_addr),
    .ev_half_o(lane_half[TX]), .ev_full_o(lane_full[TX]),
    .src_valid_i(txm_gnt), .src_data_i(txm_rdata), .src_ready_o(txm_req),
    .snk_valid_o(txs_valid), .snk_data_o(txs_data), .snk_ready_i(txs_ready)
  );

  // record: receive stream is the source, memory is the sink
  adb_lane #(.IS_RX(1'b1), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(lane_start[RX]), .stop_i(lane_stop[RX]), .loop_i(lane_loop[RX]),
    .base_i(lane_base[RX]), .len_i(lane_len[RX]),
    .active_o(lane_active[RX]), .left_o(lane_left[RX]), .addr_o(rxm_addr),
    .ev_half_o(lane_half[RX]), .ev_full_o(lane_full[RX]),
    .src_valid_i(rxs_valid), .src_data_i(rxs_data), .src_ready_o(rxs_ready),
    .snk_valid_o(rxm_req), .snk_data_o(rxm_wdata), .snk_ready_i(rxm_gnt)
  );
endmodule

// File: rtl/adb_checker.sv
module adb_checker #(
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [4:0]       reg_addr,
  input logic             wd_tx_go,
  input logic             wd_tx_halt,
  input logic             wd_rx_halt,
  input logic             wd_bit3,
  input logic [3:0]       irq,
  input logic             txm_req,
  input logic             txs_valid,
  input logic             txs_ready,
  input logic [31:0]      txs_data,
  input logic             rxm_req,
  input logic             rxm_gnt,
  input logic [31:0]      rxm_addr,
  input logic [31:0]      rxm_wdata,
  input logic             rxs_ready,
  input logic             tx_active,
  input logic             rx_active,
  input logic [CNT_W-1:0] tx_len
);
  logic ctl_wr, ev_wr;
  assign ctl_wr = reg_we && (reg_addr == 5'h10);
  assign ev_wr  = reg_we && (reg_addr == 5'h1C);

  AST_TX_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wd_tx_halt |=> !tx_active && !txm_req && !txs_valid); // R10
  AST_RX_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wd_rx_halt |=> !rx_active && !rxm_req && !rxs_ready); // R10
  AST_SHORT_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wd_tx_go && !wd_tx_halt && !tx_active && (tx_len < CNT_W'(8)) |=> !tx_active); // R5
  AST_TX_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] && !(ev_wr && wd_tx_go) |=> irq[0]); // R7
  AST_RX_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq[3] && !(ev_wr && wd_bit3) |=> irq[3]); // R7
  AST_TX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    txs_valid && !txs_ready && !(ctl_wr && wd_tx_halt) |=> txs_valid && $stable(txs_data)); // R12
  AST_RX_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rxm_req && !rxm_gnt && !(ctl_wr && wd_rx_halt) |=> rxm_req && $stable(rxm_addr) && $stable(rxm_wdata)); // R12
endmodule

bind audio_dma_bridge adb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_tx_go(reg_wdata[0]), .wd_tx_halt(reg_wdata[1]), .wd_rx_halt(reg_wdata[17]),
  .wd_bit3(reg_wdata[3]), .irq(irq),
  .txm_req(txm_req), .txs_valid(txs_valid), .txs_ready(txs_ready), .txs_data(txs_data),
  .rxm_req(rxm_req), .rxm_gnt(rxm_gnt), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata),
  .rxs_ready(rxs_ready), .tx_active(lane_active[0]), .rx_active(lane_active[1]),
  .tx_len(lane_len[0])
);

// File: tb/audio_dma_bridge_test.sv
`timescale 1ns/100ps
module audio_dma_bridge_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n, reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        txm_req, txm_gnt, txs_valid, txs_ready;
  logic [31:0] txm_addr, txm_rdata, txs_data;
  logic        rxs_valid, rxs_ready, rxm_req, rxm_gnt;
  logic [31:0] rxs_data, rxm_addr, rxm_wdata;
  logic [3:0]  irq;
  logic        tx_gnt_en, rx_gnt_en;

  assign txm_gnt   = txm_req & tx_gnt_en;
  assign txm_rdata = txm_addr ^ 32'hA5A5_0000;
  assign rxm_gnt   = rxm_req & rx_gnt_en;

  audio_dma_bridge uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txm_req(txm_req), .txm_addr(txm_addr), .txm_gnt(txm_gnt), .txm_rdata(txm_rdata),
    .txs_valid(txs_valid), .txs_data(txs_data), .txs_ready(txs_ready),
    .rxs_valid(rxs_valid), .rxs_data(rxs_data), .rxs_ready(rxs_ready),
    .rxm_req(rxm_req), .rxm_addr(rxm_addr), .rxm_wdata(rxm_wdata), .rxm_gnt(rxm_gnt),
    .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] tg_addr [64];
  logic [31:0] ts_data [64];
  logic [31:0] rw_addr [64];
  logic [31:0] rw_data [64];
  int n_tg, n_ts, n_rw;
  int ev_at [4];
  logic [31:0] rv;
  int snap;

  // address, write data, expected readback
  localparam logic [68:0] VEC [7] = '{
    {5'h00, 32'h1234_5677, 32'h1234_5674},
    {5'h04, 32'hFFFF_FFFF, 32'hFFFF_FFFC},
    {5'h08, 32'hFFFF_FFFF, 32'h03FF_FFFC},
    {5'h0C, 32'h0000_0013, 32'h0000_0010},
    {5'h10, 32'h0206_0206, 32'h0204_0204},
    {5'h10, 32'h0102_0102, 32'h0100_0100},
    {5'h10, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n_tg = 0; n_ts = 0; n_rw = 0;
    for (int k = 0; k < 4; k++) ev_at[k] = -1;
  endtask

  // called at a falling edge; samples just before the next rising edge
  task automatic step();
    logic rx_hs;
    #0.5;
    if (txm_req && txm_gnt && n_tg < 64) begin tg_addr[n_tg] = txm_addr; n_tg++; end
    if (txs_valid && txs_ready && n_ts < 64) begin ts_data[n_ts] = txs_data; n_ts++; end
    if (rxm_req && rxm_gnt && n_rw < 64) begin
      rw_addr[n_rw] = rxm_addr; rw_data[n_rw] = rxm_wdata; n_rw++;
    end
    rx_hs = rxs_valid && rxs_ready;
    for (int k = 0; k < 4; k++) if (irq[k] && ev_at[k] < 0) ev_at[k] = cyc;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (rx_hs) rxs_data = rxs_data + 32'd1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_we = 1'b0; reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_gnt_en = 1'b0; rx_gnt_en = 1'b0; txs_ready = 1'b0;
    rxs_valid = 1'b0; rxs_data = '0;
    clr_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    steps(3);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 req", {29'd0, txm_req, rxm_req, txs_valid}, 32'h0);
    chk("R1 rxs_ready", 32'(rxs_ready), 32'h0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), rv);
      chk("R1 register", rv, 32'h0);
    end

    // R2 / R3 register table
    for (int v = 0; v < 7; v++) begin
      wr(VEC[v][68:64], VEC[v][63:32]);
      rd(VEC[v][68:64], rv);
      chk(VEC[v][68:64] == 5'h10 ? "R3 control" : "R2 address/length", rv, VEC[v][31:0]);
    end

    // R5 short length ignored
    wr(5'h08, 32'd4);
    tx_gnt_en = 1'b1;
    wr(5'h10, 32'h1);
    steps(3);
    chk("R5 req", 32'(txm_req), 32'h0);
    rd(5'h10, rv);
    chk("R5 enable", rv & 32'h1, 32'h0);

    // single playback pass, 16 bytes
    wr(5'h00, 32'h100);
    wr(5'h08, 32'd16);
    txs_ready = 1'b1;
    clr_log();
    wr(5'h10, 32'h1);
    step();
    rd(5'h14, rv);
    chk("R4 count after one word", rv, 32'd12);
    steps(20);
    chk("R9 word count", n_tg, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 address", tg_addr[i], 32'h100 + 32'(4 * i));
      chk("R12 tx data", ts_data[i], (32'h100 + 32'(4 * i)) ^ 32'hA5A5_0000);
    end
    chk("R12 tx words", n_ts, 4);
    chk("R6 events", 32'(irq), 32'h3);
    chk("R6 half before full", 32'(ev_at[0] >= 0 && ev_at[1] > ev_at[0]), 32'h1);
    rd(5'h10, rv);
    chk("R9 enable cleared", rv & 32'h1, 32'h0);
    rd(5'h14, rv);
    chk("R4 count end", rv, 32'h0);

    // R7 write-one-to-clear
    wr(5'h1C, 32'h1);
    chk("R7 clear one", 32'(irq), 32'h2);
    wr(5'h1C, 32'h0);
    chk("R7 write zero", 32'(irq), 32'h2);
    wr(5'h1C, 32'hF);
    chk("R7 clear all", 32'(irq), 32'h0);

    // R8 loop over an 8-byte ring
    wr(5'h08, 32'd8);
    clr_log();
    wr(5'h10, 32'h5);
    steps(12);
    chk("R8 grant count", 32'(n_tg >= 5), 32'h1);
    for (int i = 0; i < 5; i++)
      chk("R8 ring address", tg_addr[i], (i % 2 == 0) ? 32'h100 : 32'h104);
    chk("R8 still running", 32'(irq[1]), 32'h1);

    // R11 enable cleared without stop, enable rewritten while running
    wr(5'h10, 32'h4);
    snap = n_tg;
    steps(8);
    chk("R11 keeps running", 32'(n_tg > snap), 32'h1);
    rd(5'h10, rv);
    chk("R11 enable", rv & 32'h1, 32'h1);
    clr_log();
    wr(5'h10, 32'h5);
    steps(3);
    chk("R11 no restart", 32'(n_tg >= 1 && tg_addr[0] != 32'hFFFF_FFFF), 32'h1);

    // R10 stop with a word held
    txs_ready = 1'b0;
    steps(4);
    chk("R10 word held", 32'(txs_valid), 32'h1);
    wr(5'h10, 32'h2);
    chk("R10 tx valid dropped", 32'(txs_valid), 32'h0);
    chk("R10 tx req", 32'(txm_req), 32'h0);
    txs_ready = 1'b1;
    snap = n_tg;
    steps(6);
    chk("R10 no grants", n_tg, snap);
    rd(5'h10, rv);
    chk("R10 control", rv & 32'h7, 32'h0);
    wr(5'h1C, 32'hF);

    // record pass, 12 bytes
    wr(5'h04, 32'h200);
    wr(5'h0C, 32'd12);
    rxs_data = 32'hC0DE_0000;
    rxs_valid = 1'b1;
    rx_gnt_en = 1'b1;
    clr_log();
    wr(5'h10, 32'h0001_0000);
    steps(20);
    chk("R9 rx writes", n_rw, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 rx address", rw_addr[i], 32'h200 + 32'(4 * i));
      chk("R12 rx data", rw_data[i], 32'hC0DE_0000 + 32'(i));
    end
    chk("R6 rx events", 32'(irq), 32'hC);
    chk("R6 rx half before full", 32'(ev_at[2] >= 0 && ev_at[3] > ev_at[2]), 32'h1);
    rd(5'h10, rv);
    chk("R9 rx enable cleared", rv & 32'h0001_0000, 32'h0);
    rd(5'h18, rv);
    chk("R4 rx count end", rv, 32'h0);

    // R10 record stop while a write waits
    wr(5'h1C, 32'hF);
    wr(5'h0C, 32'h40);
    rx_gnt_en = 1'b0;
    wr(5'h10, 32'h0001_0000);
    steps(4);
    chk("R12 rx write waits", 32'(rxm_req), 32'h1);
    wr(5'h10, 32'h0002_0000);
    chk("R10 rx req", 32'(rxm_req), 32'h0);
    chk("R10 rx ready", 32'(rxs_ready), 32'h0);
    rd(5'h10, rv);
    chk("R10 rx enable", rv & 32'h0001_0000, 32'h0);

    finish_run();
  end
endmodule